// File: doc/BRIEF.md
# DMA Request and Acknowledge Handshake Glue

This block sits between a byte-wide host bus, an external DMA controller and a 32-entry data FIFO that serves both transmit and receive. It watches the FIFO fill level, the programmed transmit and receive thresholds, a receive timeout flag and a transmit-empty event. From these it drives a request line toward the DMA controller. The polarity of that line can be programmed.

On the bus side, the block turns chip-select, acknowledge, read and write strobes into single-cycle pulses. Each pulse either pushes or pops the FIFO, or is handed on as an access to another register, together with the address that was captured. While acknowledge is active, every strobe is steered to the data register. A terminal-count input ends a burst. A 3-bit mode register sets the enable, the polarity, and whether acknowledge is honoured or ignored in favour of ordinary chip-select cycles. Only single and demand transfers are handled.

Top module: `dma_hs_top`

## Requirements
- R1: The mode register is written through `mode_we`/`mode_wdata` and takes effect on the next clock. Its bit 0 is the enable, bit 1 is the polarity and bit 2 is the acknowledge-ignore flag. It resets to 000.
- R2: While the enable bit is 0, `dreq` holds its inactive level, whatever the FIFO conditions are.
- R3: When polarity is 0, `dreq` is active low and `dack` is active high. When polarity is 1, `dreq` is active high and `dack` is active low. The inactive level of `dreq` is therefore the inverse of the polarity bit.
- R4: When the block is enabled and acknowledge-ignore is 0, an active `dack` selects the block without `cs_n`. Any strobe edge in that state reaches the data register (address 0), whatever `addr` carries, and appears on `fifo_pop` or `fifo_push`, never on `reg_rd` or `reg_wr`.
- R5: When acknowledge-ignore is 1, `dack` has no effect. Strobes count only while `cs_n` is low, and `addr` decides the target. The request polarity still follows bit 1.
- R6: In receive, the request goes active once the FIFO level is at or above `rx_thresh`, or once `rx_timeout` is set. It stays active until the level reaches 0.
- R7: In transmit, the request goes active once the level is below `tx_thresh`. It drops when the level equals 32 or when `tx_empty_ev` fires. After `tx_empty_ev`, it re-arms only when the level first rises to or above the threshold and then falls below it again.
- R8: With both `rx_mode` and `tx_mode` set, the receive rules apply. With neither set, no request is made.
- R9: When `tc_n` is low at the strobe edge of a data-register transfer, the request drops. It stays inactive until its assert condition goes false and then true again.
- R10: Each falling edge of an active strobe gives exactly one pulse, one clock after the edge is sampled, however long the strobe is held.
- R11: A strobe edge aimed at any address other than 0 pulses `reg_rd` or `reg_wr`. `reg_addr` holds the captured address until the next access.
- R12: The request pin is registered. It changes one clock after the inputs that cause the change are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | Mode value: bit0 enable, bit1 polarity, bit2 acknowledge-ignore |
| rx_mode | input | 1 | Receive direction active |
| tx_mode | input | 1 | Transmit direction active |
| fifo_level | input | 6 | Current FIFO occupancy, 0 to 32 |
| rx_thresh | input | 6 | Receive threshold in bytes |
| tx_thresh | input | 6 | Transmit threshold in bytes |
| rx_timeout | input | 1 | Receive timeout has occurred |
| tx_empty_ev | input | 1 | One-cycle transmit-empty event |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| dack | input | 1 | DMA acknowledge, polarity set by mode bit 1 |
| tc_n | input | 1 | Terminal count, active low |
| dreq | output | 1 | DMA request, polarity set by mode bit 1 |
| fifo_pop | output | 1 | One-cycle pulse: a data-register read |
| fifo_push | output | 1 | One-cycle pulse: a data-register write |
| reg_rd | output | 1 | One-cycle pulse: a read of another register |
| reg_wr | output | 1 | One-cycle pulse: a write of another register |
| reg_addr | output | 4 | Address captured at the last access |

## Verification
The bench holds a strobe low for several cycles. A level-based decoder would then push or pop once per cycle and over-run the FIFO. It places a non-zero address under an active acknowledge, and a design that still decodes `addr` would raise a register pulse instead of a pop. In transmit, it leaves the level below threshold after `tx_empty_ev` and after a terminal count, so a design that re-arms on level rather than on a crossing would request again at once. It also sets both directions together, where transmit-first priority would invert the request, and it programs both polarities, so an inverted-pin mistake cannot pass as correct.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    // Packed so that bit 2 = ack_ignore, bit 1 = pol_high, bit 0 = enable
    typedef struct packed {
        logic ack_ignore;
        logic pol_high;
        logic enable;
    } dma_mode_t;

    typedef struct packed {
        logic armed;
        logic cond;
        logic req;
        logic pin;
    } req_state_t;

    localparam logic [2:0] MODE_RESET = 3'b000;

endpackage

// File: rtl/dma_hs_strobe.sv
module dma_hs_strobe
    import dma_hs_pkg::*;
#(
    parameter int                 ADDR_W    = 4,
    parameter logic [ADDR_W-1:0]  DATA_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_mode_t         mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dack,
    input  logic              tc_n,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              tc_hit
);

    typedef struct packed {
        logic              rd_prev;
        logic              wr_prev;
        logic              pop;
        logic              push;
        logic              rrd;
        logic              rwr;
        logic              tc;
        logic [ADDR_W-1:0] addr;
    } strobe_state_t;

    strobe_state_t st_q, st_d;

    logic              ack_on;
    logic              sel;
    logic              rd_act;
    logic              wr_act;
    logic              rd_edge;
    logic              wr_edge;
    logic [ADDR_W-1:0] eff_addr;
    logic              is_data;

    always_comb begin
        // Acknowledge counts only when enabled and not ignored; its
        // active level is the inverse of the request's.
        ack_on   = mode.enable & ~mode.ack_ignore & (dack ^ mode.pol_high);
        sel      = ~cs_n | ack_on;
        rd_act   = sel & ~rd_n;
        wr_act   = sel & ~wr_n;
        rd_edge  = rd_act & ~st_q.rd_prev;
        wr_edge  = wr_act & ~st_q.wr_prev;
        eff_addr = ack_on ? DATA_ADDR : addr;
        is_data  = (eff_addr == DATA_ADDR);

        st_d         = st_q;
        st_d.rd_prev = rd_act;
        st_d.wr_prev = wr_act;
        st_d.pop     = rd_edge & is_data;
        st_d.push    = wr_edge & is_data;
        st_d.rrd     = rd_edge & ~is_data;
        st_d.rwr     = wr_edge & ~is_data;
        st_d.tc      = ~tc_n & ((rd_edge | wr_edge) & is_data);
        if (rd_edge | wr_edge) begin
            st_d.addr = eff_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_pop  = st_q.pop;
    assign fifo_push = st_q.push;
    assign reg_rd    = st_q.rrd;
    assign reg_wr    = st_q.rwr;
    assign reg_addr  = st_q.addr;
    assign tc_hit    = st_q.tc;

endmodule

// File: rtl/dma_hs_req.sv
module dma_hs_req
    import dma_hs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_t        mode,
    input  logic             rx_mode,
    input  logic             tx_mode,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic             rx_timeout,
    input  logic             tx_empty_ev,
    input  logic             tc_hit,
    output logic             dreq_pin
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    req_state_t st_q, st_d;

    logic rx_side;
    logic tx_side;
    logic idle;
    logic cond;
    logic clear;
    logic disarm;
    logic rise;

    always_comb begin
        rx_side = rx_mode;
        tx_side = tx_mode & ~rx_mode;
        idle    = ~mode.enable | (~rx_side & ~tx_side);

        if (rx_side) begin
            cond  = (fifo_level >= rx_thresh) | rx_timeout;
            clear = (fifo_level == '0);
        end else if (tx_side) begin
            cond  = (fifo_level < tx_thresh);
            clear = (fifo_level == FULL_LVL) | tx_empty_ev;
        end else begin
            cond  = 1'b0;
            clear = 1'b1;
        end

        disarm = tc_hit | (tx_side & tx_empty_ev);
        rise   = cond & ~st_q.cond;

        st_d      = st_q;
        st_d.cond = idle ? 1'b0 : cond;

        if (idle) begin
            st_d.armed = 1'b1;
        end else if (disarm) begin
            st_d.armed = 1'b0;
        end else if (rise) begin
            st_d.armed = 1'b1;
        end

        if (idle || clear || tc_hit) begin
            st_d.req = 1'b0;
        end else if (cond && st_d.armed) begin
            st_d.req = 1'b1;
        end

        // Inactive level is the inverse of the polarity bit
        st_d.pin = mode.pol_high ? st_d.req : ~st_d.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, cond: 1'b0, req: 1'b0, pin: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dreq_pin = st_q.pin;

endmodule

// File: rtl/dma_hs_top.sv
module dma_hs_top
    import dma_hs_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_wdata,
    input  logic              rx_mode,
    input  logic              tx_mode,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic              rx_timeout,
    input  logic              tx_empty_ev,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dack,
    input  logic              tc_n,
    output logic              dreq,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr
);

    dma_mode_t mode_q, mode_d;
    logic      tc_hit;

    always_comb begin
        mode_d = mode_q;
        if (mode_we) begin
            mode_d = dma_mode_t'(mode_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= dma_mode_t'(MODE_RESET);
        end else begin
            mode_q <= mode_d;
        end
    end

    dma_hs_strobe #(
        .ADDR_W    (ADDR_W),
        .DATA_ADDR ('0)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .dack      (dack),
        .tc_n      (tc_n),
        .fifo_pop  (fifo_pop),
        .fifo_push (fifo_push),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .tc_hit    (tc_hit)
    );

    dma_hs_req #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .rx_mode     (rx_mode),
        .tx_mode     (tx_mode),
        .fifo_level  (fifo_level),
        .rx_thresh   (rx_thresh),
        .tx_thresh   (tx_thresh),
        .rx_timeout  (rx_timeout),
        .tx_empty_ev (tx_empty_ev),
        .tc_hit      (tc_hit),
        .dreq_pin    (dreq)
    );

endmodule

// File: rtl/dma_hs_check.sv
module dma_hs_check #(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_q,
    input logic             rx_mode,
    input logic             tx_mode,
    input logic [LVL_W-1:0] fifo_level,
    input logic             dack,
    input logic             dreq,
    input logic             fifo_pop,
    input logic             fifo_push,
    input logic             reg_rd,
    input logic             reg_wr
);

    logic ack_live;
    assign ack_live = mode_q[0] & ~mode_q[2] & (dack ^ mode_q[1]);

    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] |=> dreq == !$past(mode_q[1]));

    a_r6_rx_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && rx_mode && fifo_level == '0) |=> dreq == !$past(mode_q[1]));

    a_r7_tx_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && tx_mode && !rx_mode && fifo_level == LVL_W'(DEPTH))
        |=> dreq == !$past(mode_q[1]));

    a_r8_no_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && !rx_mode && !tx_mode) |=> dreq == !$past(mode_q[1]));

    a_r10_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    a_r10_one_push: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);

    a_r4_ack_forces_data: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> !$past(ack_live));

    a_r11_targets_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((fifo_pop || fifo_push) && (reg_rd || reg_wr)));

endmodule

bind dma_hs_top dma_hs_check #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .rx_mode    (rx_mode),
    .tx_mode    (tx_mode),
    .fifo_level (fifo_level),
    .dack       (dack),
    .dreq       (dreq),
    .fifo_pop   (fifo_pop),
    .fifo_push  (fifo_push),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr)
);

// File: tb/dma_hs_top_test.sv
module dma_hs_top_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic       rx_mode = 1'b0, tx_mode = 1'b0;
    logic [5:0] fifo_level = '0, rx_thresh = 6'd8, tx_thresh = 6'd14;
    logic       rx_timeout = 1'b0, tx_empty_ev = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic       dack = 1'b0, tc_n = 1'b1;
    logic       dreq, fifo_pop, fifo_push, reg_rd, reg_wr;
    logic [3:0] reg_addr;

    int n_chk = 0, n_fail = 0;
    int pop_cnt = 0, push_cnt = 0, rrd_cnt = 0, rwr_cnt = 0;
    logic pol = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_hs_top uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .rx_mode(rx_mode), .tx_mode(tx_mode), .fifo_level(fifo_level),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .rx_timeout(rx_timeout),
        .tx_empty_ev(tx_empty_ev), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .dack(dack), .tc_n(tc_n), .dreq(dreq),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr)
    );

    always @(negedge clk) begin
        if (fifo_pop)  pop_cnt++;
        if (fifo_push) push_cnt++;
        if (reg_rd)    rrd_cnt++;
        if (reg_wr)    rwr_cnt++;
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // active=1 means a request is expected; pin level follows polarity (R3)
    task automatic chk_req(input logic active, input string tag);
        chk(int'(dreq), int'(pol ? active : !active), tag);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
        pol = m[1];
        tick(2);
    endtask

    task automatic quiet();
        rx_mode = 0; tx_mode = 0; fifo_level = 0; rx_timeout = 0;
        tx_empty_ev = 0; cs_n = 1; rd_n = 1; wr_n = 1; dack = 0; tc_n = 1; addr = 0;
        tick(2);
    endtask

    task automatic strobe(input logic is_rd, input int len);
        @(negedge clk);
        if (is_rd) rd_n = 0; else wr_n = 0;
        tick(len);
        rd_n = 1; wr_n = 1;
        tick(2);
    endtask

    task automatic t_reset();
        chk(int'(dreq), 1, "R1 reset leaves request inactive-low idle");
        chk(pop_cnt + push_cnt + rrd_cnt + rwr_cnt, 0, "R1 no pulses after reset");
    endtask

    task automatic t_disabled();
        rx_mode = 1; fifo_level = 20; rx_timeout = 1;
        tick(3);
        chk_req(0, "R2 disabled pol0 holds idle");
        set_mode(3'b010);
        chk_req(0, "R2 disabled pol1 holds idle");
        chk(int'(dreq), 0, "R3 idle level of active-high request");
        quiet();
    endtask

    task automatic t_rx();
        set_mode(3'b001);
        rx_mode = 1; rx_thresh = 8; fifo_level = 4; tick(2);
        chk_req(0, "R6 below rx threshold");
        fifo_level = 8; tick(2);
        chk_req(1, "R6 at rx threshold");
        fifo_level = 3; tick(2);
        chk_req(1, "R6 held until empty");
        fifo_level = 0; tick(2);
        chk_req(0, "R6 dropped on empty");
        fifo_level = 1; rx_timeout = 1; tick(2);
        chk_req(1, "R6 timeout requests");
        rx_timeout = 0;
        set_mode(3'b011);
        fifo_level = 0; tick(2);
        fifo_level = 9; tick(2);
        chk_req(1, "R3 active-high request asserted");
        chk(int'(dreq), 1, "R3 pin high when requesting with pol1");
        quiet();
    endtask

    task automatic t_tx();
        set_mode(3'b001);
        tx_mode = 1; tx_thresh = 14; fifo_level = 20; tick(2);
        chk_req(0, "R7 above tx threshold");
        fifo_level = 13; tick(2);
        chk_req(1, "R7 below tx threshold");
        fifo_level = 20; tick(2);
        chk_req(1, "R7 held until full");
        fifo_level = 32; tick(2);
        chk_req(0, "R7 dropped when full");
        fifo_level = 10; tick(2);
        chk_req(1, "R7 reasserts below threshold");
        fifo_level = 0;
        @(negedge clk); tx_empty_ev = 1;
        @(negedge clk); tx_empty_ev = 0;
        tick(3);
        chk_req(0, "R7 empty event drops and disarms");
        fifo_level = 20; tick(2);
        fifo_level = 5; tick(2);
        chk_req(1, "R7 crossing rearms");
        quiet();
    endtask

    task automatic t_both();
        set_mode(3'b001);
        rx_mode = 1; tx_mode = 1; rx_thresh = 8; tx_thresh = 14; fifo_level = 0; tick(3);
        chk_req(0, "R8 receive rules win when level empty");
        fifo_level = 20; tick(2);
        chk_req(1, "R8 receive rules win above rx threshold");
        rx_mode = 0; tx_mode = 0; tick(2);
        chk_req(0, "R8 no direction no request");
        quiet();
    endtask

    task automatic t_ack();
        int p0, w0, r0;
        set_mode(3'b001);
        dack = 1; addr = 5; cs_n = 1;
        p0 = pop_cnt; r0 = rrd_cnt;
        strobe(1, 5);
        chk(pop_cnt - p0, 1, "R10 long read strobe pops once");
        chk(rrd_cnt - r0, 0, "R4 ack read ignores address");
        w0 = push_cnt;
        strobe(0, 4);
        chk(push_cnt - w0, 1, "R4 ack write pushes once");
        dack = 0; p0 = pop_cnt;
        strobe(1, 2);
        chk(pop_cnt - p0, 0, "R3 ack inactive high-level blocks access");
        set_mode(3'b011);
        dack = 0; p0 = pop_cnt;
        strobe(1, 2);
        chk(pop_cnt - p0, 1, "R3 active-low ack honoured");
        quiet();
    endtask

    task automatic t_ignore();
        int p0, r0, w0;
        set_mode(3'b101);
        dack = 1; cs_n = 1; p0 = pop_cnt;
        strobe(1, 2);
        chk(pop_cnt - p0, 0, "R5 ack ignored without chip select");
        cs_n = 0; addr = 0; p0 = pop_cnt;
        strobe(1, 2);
        chk(pop_cnt - p0, 1, "R5 chip select data read");
        addr = 5; r0 = rrd_cnt; p0 = pop_cnt;
        strobe(1, 3);
        chk(rrd_cnt - r0, 1, "R11 other register read pulse");
        chk(pop_cnt - p0, 0, "R11 other register leaves fifo");
        chk(int'(reg_addr), 5, "R11 captured address");
        addr = 9; w0 = rwr_cnt;
        strobe(0, 1);
        chk(rwr_cnt - w0, 1, "R11 other register write pulse");
        chk(int'(reg_addr), 9, "R11 address updated on write");
        set_mode(3'b001);
        dack = 1; cs_n = 0; addr = 6; r0 = rrd_cnt; p0 = pop_cnt;
        strobe(1, 2);
        chk(pop_cnt - p0, 1, "R4 ack overrides chip-select address");
        chk(rrd_cnt - r0, 0, "R4 no register read under ack");
        quiet();
    endtask

    task automatic t_tc();
        set_mode(3'b001);
        rx_mode = 1; rx_thresh = 8; fifo_level = 10; tick(2);
        chk_req(1, "R9 request before terminal count");
        dack = 1; tc_n = 0;
        strobe(1, 1);
        tc_n = 1; dack = 0; tick(1);
        chk_req(0, "R9 terminal count drops request");
        tick(3);
        chk_req(0, "R9 stays dropped while level high");
        fifo_level = 4; tick(2);
        fifo_level = 10; tick(2);
        chk_req(1, "R9 rearmed by new crossing");
        quiet();
    endtask

    task automatic t_timing();
        set_mode(3'b001);
        rx_mode = 1; rx_thresh = 8; fifo_level = 2; tick(2);
        @(negedge clk); fifo_level = 12;
        #1 chk_req(0, "R12 not yet before sampling edge");
        @(negedge clk);
        chk_req(1, "R12 one clock after sampling");
        set_mode(3'b000);
        chk_req(0, "R1 mode rewrite disables");
        quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_disabled();
        t_rx();
        t_tx();
        t_both();
        t_ack();
        t_ignore();
        t_tc();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule